// File: doc/BRIEF.md
# Square Voice Pitch Sweep Unit

This block bends the pitch of one square-wave voice up or down at a steady rate. It holds the voice's 11-bit frequency register. Each time the sweep steps, it rewrites that register with the old value plus or minus a right-shifted copy of itself. The sweep runs from a private shadow copy that is captured when the voice is triggered. Frequency writes made by software after the trigger therefore change what is heard only until the next step, and they never change where the sweep goes next.

The block works out every upward step one step early. If the next value would no longer fit in 11 bits, it emits a one-cycle `chan_off` pulse at once, and the out-of-range value is never written. The same check runs on the trigger itself. A starting pitch that is already too high therefore silences the voice before it plays a single step. When the shift amount is zero, the pitch does not move. The update counter then works as a one-shot timer whose expiry turns the voice off. The step counter is advanced by a 128 Hz tick strobe supplied from outside.

Top module: `pitch_sweep`

## Requirements
- R1: While `rst` is high, on each clock edge `freq_out` becomes 0 and `chan_off` becomes 0.
- R2: A cycle with `freq_wr` high puts `freq_wdata` on `freq_out` after that clock edge. This holds even when a sweep step falls in the same cycle.
- R3: A trigger copies the current frequency into the shadow register. Later steps are computed from the shadow, so a frequency write made after the trigger does not change the value of the next step.
- R4: With a period field P (`sweep_cfg[6:4]`) other than 0, the first step happens on tick number P+1 after the trigger, and further steps follow every P+1 ticks.
- R5: With the direction bit `sweep_cfg[3]` at 0 and a shift S (`sweep_cfg[2:0]`) other than 0, a step writes f + (f >> S) to `freq_out`.
- R6: With the direction bit at 1, a step writes f - (f >> S), kept at 11 bits. A downward sweep never raises `chan_off`.
- R7: With the period field at 0, ticks are ignored: `freq_out` holds its value and `chan_off` stays low.
- R8: With a shift of 0 and a non-zero period, the frequency never changes. On the tick where a step would fall, `chan_off` pulses instead.
- R9: An upward trigger whose first step would exceed 0x7FF pulses `chan_off` in the cycle after the trigger. After that, ticks change nothing.
- R10: After an upward step writes value g, `chan_off` pulses in that same cycle if g + (g >> S) exceeds 0x7FF. The voice then stops, and g stays on `freq_out`.
- R11: `chan_off` is high for one cycle per disable event. Once the voice is disabled, no tick changes `freq_out` or raises `chan_off` until the next trigger.
- R12: For shifts 1 to 7, an upward trigger disables the voice exactly when the frequency is at or above 0x556, 0x667, 0x71D, 0x788, 0x7C2, 0x7E1 or 0x7F1 respectively. A shift of 0 never disables at trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_cfg | input | 7 | [6:4] step period, [3] direction (1 = down), [2:0] shift amount |
| freq_wr | input | 1 | Frequency register write strobe |
| freq_wdata | input | 11 | Frequency value to write |
| trig | input | 1 | Voice trigger pulse |
| tick_128 | input | 1 | 128 Hz step tick strobe, one cycle wide |
| freq_out | output | 11 | Current frequency register value |
| chan_off | output | 1 | One-cycle pulse that disables the voice |

## Verification
A wrong shadow value cannot be seen at the ports until the next step. That step can come up to eight ticks after the trigger, and it then shows as a wrong `freq_out` value. A fault in the overflow look-ahead shows up sooner: `chan_off` is missing or comes too early, either one cycle after a trigger or in the cycle of a step. Sweeping every frequency against every shift at trigger time pins down each threshold exactly. A grid over period, direction and shift exposes any miscount in the step counter as a step on the wrong tick.

// File: rtl/pitch_sweep_pkg.sv
package pitch_sweep_pkg;

    localparam int DEF_FREQ_W = 11;
    localparam int DEF_PER_W  = 3;
    localparam int DEF_SH_W   = 3;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2,
        ACT_STOP = 2'd3
    } sweep_act_e;

endpackage

// File: rtl/sweep_step_calc.sv
module sweep_step_calc #(
    parameter int FREQ_W = 11,
    parameter int SH_W   = 3
) (
    input  logic [FREQ_W-1:0] base,
    input  logic [SH_W-1:0]   shift,
    input  logic              down,
    output logic [FREQ_W-1:0] result,
    output logic              ovf
);
    logic [FREQ_W-1:0] delta;
    logic [FREQ_W:0]   wide_sum;

    assign delta    = base >> shift;
    assign wide_sum = {1'b0, base} + {1'b0, delta};

    always_comb begin
        if (down) begin
            result = base - delta;
            ovf    = 1'b0;
        end else begin
            result = wide_sum[FREQ_W-1:0];
            ovf    = wide_sum[FREQ_W] && (shift != '0);
        end
    end
endmodule

// File: rtl/sweep_period_timer.sv
module sweep_period_timer #(
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             en,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             fire
);
    logic [PER_W-1:0] cnt_q;
    logic             clk_on;

    assign clk_on = en && tick && (period != '0);
    assign fire   = clk_on && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (clk_on) begin
            cnt_q <= fire ? period : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sweep_state.sv
module sweep_state
    import pitch_sweep_pkg::*;
#(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_wdata,
    input  logic [FREQ_W-1:0] trig_src,
    input  logic              trig_ovf,
    input  logic              fire,
    input  logic              shift_zero,
    input  logic [FREQ_W-1:0] step_res,
    input  logic              step_ovf,
    input  logic              ahead_ovf,
    output logic [FREQ_W-1:0] freq_q,
    output logic [FREQ_W-1:0] shadow_q,
    output logic              run_q,
    output logic              off_q
);
    sweep_act_e act;

    always_comb begin
        act = ACT_IDLE;
        if (trig) begin
            act = ACT_LOAD;
        end else if (fire) begin
            if (shift_zero || step_ovf) act = ACT_STOP;
            else                        act = ACT_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            run_q    <= 1'b0;
            off_q    <= 1'b0;
        end else begin
            off_q <= 1'b0;
            case (act)
                ACT_LOAD: begin
                    shadow_q <= trig_src;
                    run_q    <= !trig_ovf;
                    off_q    <= trig_ovf;
                end
                ACT_STEP: begin
                    shadow_q <= step_res;
                    run_q    <= !ahead_ovf;
                    off_q    <= ahead_ovf;
                end
                ACT_STOP: begin
                    run_q <= 1'b0;
                    off_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
        end else if (freq_wr) begin
            freq_q <= freq_wdata;
        end else if (act == ACT_STEP) begin
            freq_q <= step_res;
        end
    end
endmodule

// File: rtl/pitch_sweep.sv
module pitch_sweep
    import pitch_sweep_pkg::*;
#(
    parameter int FREQ_W = DEF_FREQ_W,
    parameter int PER_W  = DEF_PER_W,
    parameter int SH_W   = DEF_SH_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PER_W+SH_W:0]   sweep_cfg,
    input  logic                  freq_wr,
    input  logic [FREQ_W-1:0]     freq_wdata,
    input  logic                  trig,
    input  logic                  tick_128,
    output logic [FREQ_W-1:0]     freq_out,
    output logic                  chan_off
);
    localparam int DIR_BIT = SH_W;
    localparam int PER_LSB = SH_W + 1;

    logic [SH_W-1:0]   cfg_shift;
    logic [PER_W-1:0]  cfg_period;
    sweep_dir_e        cfg_dir;
    logic              is_down;

    logic [FREQ_W-1:0] freq_q;
    logic [FREQ_W-1:0] shadow_q;
    logic              run_q;
    logic              off_q;
    logic [FREQ_W-1:0] trig_src;
    logic              fire;

    logic [FREQ_W-1:0] trig_res_unused;
    logic              trig_ovf;
    logic [FREQ_W-1:0] step_res;
    logic              step_ovf;
    logic [FREQ_W-1:0] ahead_res_unused;
    logic              ahead_ovf;

    assign cfg_shift  = sweep_cfg[SH_W-1:0];
    assign cfg_dir    = sweep_dir_e'(sweep_cfg[DIR_BIT]);
    assign cfg_period = sweep_cfg[PER_LSB +: PER_W];
    assign is_down    = (cfg_dir == SWEEP_DOWN);

    // A write in the trigger cycle is the value the sweep starts from.
    assign trig_src = freq_wr ? freq_wdata : freq_q;

    sweep_step_calc #(.FREQ_W(FREQ_W), .SH_W(SH_W)) u_calc_trig (
        .base   (trig_src),
        .shift  (cfg_shift),
        .down   (is_down),
        .result (trig_res_unused),
        .ovf    (trig_ovf)
    );

    sweep_step_calc #(.FREQ_W(FREQ_W), .SH_W(SH_W)) u_calc_step (
        .base   (shadow_q),
        .shift  (cfg_shift),
        .down   (is_down),
        .result (step_res),
        .ovf    (step_ovf)
    );

    // Look one step ahead of the value about to be written.
    sweep_step_calc #(.FREQ_W(FREQ_W), .SH_W(SH_W)) u_calc_ahead (
        .base   (step_res),
        .shift  (cfg_shift),
        .down   (is_down),
        .result (ahead_res_unused),
        .ovf    (ahead_ovf)
    );

    sweep_period_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (trig),
        .en     (run_q),
        .tick   (tick_128),
        .period (cfg_period),
        .fire   (fire)
    );

    sweep_state #(.FREQ_W(FREQ_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .freq_wr    (freq_wr),
        .freq_wdata (freq_wdata),
        .trig_src   (trig_src),
        .trig_ovf   (trig_ovf),
        .fire       (fire),
        .shift_zero (cfg_shift == '0),
        .step_res   (step_res),
        .step_ovf   (step_ovf),
        .ahead_ovf  (ahead_ovf),
        .freq_q     (freq_q),
        .shadow_q   (shadow_q),
        .run_q      (run_q),
        .off_q      (off_q)
    );

    assign freq_out = freq_q;
    assign chan_off = off_q;
endmodule

// File: rtl/pitch_sweep_chk.sv
module pitch_sweep_chk #(
    parameter int FREQ_W = 11,
    parameter int PER_W  = 3,
    parameter int SH_W   = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                trig,
    input logic                freq_wr,
    input logic [FREQ_W-1:0]   freq_wdata,
    input logic [PER_W+SH_W:0] sweep_cfg,
    input logic [FREQ_W-1:0]   freq_out,
    input logic                chan_off,
    input logic [FREQ_W-1:0]   shadow_q,
    input logic                run_q
);
    logic [SH_W-1:0]  c_shift;
    logic             c_down;
    logic [PER_W-1:0] c_period;

    assign c_shift  = sweep_cfg[SH_W-1:0];
    assign c_down   = sweep_cfg[SH_W];
    assign c_period = sweep_cfg[SH_W+1 +: PER_W];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        freq_wr |=> (freq_out == $past(freq_wdata)));

    // R5
    up_never_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && !c_down && c_shift != '0) |=> (shadow_q >= $past(shadow_q)));

    // R6
    down_never_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && c_down) |=> (shadow_q <= $past(shadow_q)));

    // R7
    period_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (c_period == '0 && !trig && !freq_wr) |=> $stable(freq_out));

    // R8
    shift_zero_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && c_shift == '0) |=> $stable(shadow_q));

    // R11
    idle_no_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && !run_q) |=> !chan_off);

    // R10
    off_means_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        chan_off |-> !run_q);
endmodule

bind pitch_sweep pitch_sweep_chk #(
    .FREQ_W (FREQ_W),
    .PER_W  (PER_W),
    .SH_W   (SH_W)
) u_pitch_sweep_chk (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .freq_wr    (freq_wr),
    .freq_wdata (freq_wdata),
    .sweep_cfg  (sweep_cfg),
    .freq_out   (freq_out),
    .chan_off   (chan_off),
    .shadow_q   (shadow_q),
    .run_q      (run_q)
);

// File: tb/pitch_sweep_bench.sv
module pitch_sweep_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  sweep_cfg;
    logic        freq_wr;
    logic [10:0] freq_wdata;
    logic        trig;
    logic        tick_128;
    logic [10:0] freq_out;
    logic        chan_off;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pitch_sweep u_pitch_sweep (
        .clk        (clk),
        .rst        (rst),
        .sweep_cfg  (sweep_cfg),
        .freq_wr    (freq_wr),
        .freq_wdata (freq_wdata),
        .trig       (trig),
        .tick_128   (tick_128),
        .freq_out   (freq_out),
        .chan_off   (chan_off)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input int f);
        freq_wr = 1'b1; freq_wdata = 11'(f);
        cyc();
        freq_wr = 1'b0;
    endtask

    task automatic do_trig();
        trig = 1'b1;
        cyc();
        trig = 1'b0;
    endtask

    task automatic do_tick();
        tick_128 = 1'b1;
        cyc();
        tick_128 = 1'b0;
    endtask

    function automatic logic [6:0] mkcfg(input int p, input int d, input int s);
        return {3'(p), 1'(d), 3'(s)};
    endfunction

    function automatic int thr(input int s);
        case (s)
            1: return 'h556;
            2: return 'h667;
            3: return 'h71D;
            4: return 'h788;
            5: return 'h7C2;
            6: return 'h7E1;
            default: return 'h7F1;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sweep_cfg = '0; freq_wr = 1'b0; freq_wdata = '0;
        trig = 1'b0; tick_128 = 1'b0;
        repeat (3) cyc();
        chk(freq_out == 11'h0, "R1 reset freq", freq_out, 0);
        chk(chan_off == 1'b0, "R1 reset off", chan_off, 0);
        rst = 1'b0;

        // R2: write is visible and holds
        wr('h123);
        chk(freq_out == 11'h123, "R2 write", freq_out, 'h123);
        repeat (3) cyc();
        chk(freq_out == 11'h123, "R2 hold", freq_out, 'h123);

        // R7: period zero ignores ticks
        sweep_cfg = mkcfg(0, 0, 1);
        wr('h100);
        do_trig();
        chk(chan_off == 1'b0, "R7 trig no off", chan_off, 0);
        for (int k = 0; k < 10; k++) begin
            do_tick();
            chk(freq_out == 11'h100 && chan_off == 1'b0, "R7 tick ignored", freq_out, 'h100);
        end

        // R3: write after trigger does not steer the sweep
        sweep_cfg = mkcfg(1, 0, 1);
        wr('h200);
        do_trig();
        chk(chan_off == 1'b0, "R3 trig no off", chan_off, 0);
        wr('h050);
        chk(freq_out == 11'h050, "R2 write mid sweep", freq_out, 'h050);
        do_tick();
        chk(freq_out == 11'h050, "R4 no step on first tick", freq_out, 'h050);
        do_tick();
        chk(freq_out == 11'h300, "R3 step from shadow", freq_out, 'h300);
        chk(chan_off == 1'b0, "R3 no off", chan_off, 0);

        // R8: shift zero acts as timer
        sweep_cfg = mkcfg(2, 0, 0);
        wr('h345);
        do_trig();
        chk(chan_off == 1'b0, "R8 trig no off", chan_off, 0);
        do_tick();
        chk(chan_off == 1'b0, "R8 tick1", chan_off, 0);
        do_tick();
        chk(chan_off == 1'b0, "R8 tick2", chan_off, 0);
        do_tick();
        chk(chan_off == 1'b1, "R8 expiry off", chan_off, 1);
        chk(freq_out == 11'h345, "R8 freq unchanged", freq_out, 'h345);
        cyc();
        chk(chan_off == 1'b0, "R11 single pulse", chan_off, 0);
        for (int k = 0; k < 6; k++) begin
            do_tick();
            chk(chan_off == 1'b0 && freq_out == 11'h345, "R11 stopped", chan_off, 0);
        end

        // R9: trigger-time overflow
        sweep_cfg = mkcfg(1, 0, 1);
        wr('h600);
        do_trig();
        chk(chan_off == 1'b1, "R9 trig off", chan_off, 1);
        cyc();
        chk(chan_off == 1'b0, "R11 trig pulse width", chan_off, 0);
        for (int k = 0; k < 4; k++) begin
            do_tick();
            chk(chan_off == 1'b0 && freq_out == 11'h600, "R9 no steps", freq_out, 'h600);
        end

        // R6 / R12: down and shift zero never off at trigger
        sweep_cfg = mkcfg(1, 1, 1);
        wr('h7FF);
        do_trig();
        chk(chan_off == 1'b0, "R6 down trig no off", chan_off, 0);
        sweep_cfg = mkcfg(0, 0, 0);
        wr('h7FF);
        do_trig();
        chk(chan_off == 1'b0, "R12 shift0 no threshold", chan_off, 0);

        // R4 R5 R6 R10: grid over period, direction, shift
        for (int p = 1; p < 8; p++) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 1; s < 8; s++) begin
                    int f;
                    bit alive;
                    bit exp_off;
                    f = 'h300 + 'h25 * p;
                    sweep_cfg = mkcfg(p, d, s);
                    wr(f);
                    do_trig();
                    alive = !(d == 0 && (f + (f >> s)) > 2047);
                    chk(chan_off == !alive, "R9 grid trig", chan_off, !alive);
                    for (int k = 1; k <= 4 * (p + 1); k++) begin
                        do_tick();
                        exp_off = 1'b0;
                        if (alive && (k % (p + 1)) == 0) begin
                            if (d == 1) f = f - (f >> s);
                            else        f = f + (f >> s);
                            exp_off = (d == 0 && (f + (f >> s)) > 2047);
                            alive = !exp_off;
                        end
                        chk(freq_out == 11'(f), d ? "R6 R4 down step" : "R5 R4 up step", freq_out, f);
                        chk(chan_off == exp_off, "R10 ahead off", chan_off, exp_off);
                    end
                end
            end
        end

        // R12: every frequency against every shift at trigger
        for (int s = 1; s < 8; s++) begin
            sweep_cfg = mkcfg(0, 0, s);
            for (int f = 0; f < 2048; f++) begin
                wr(f);
                do_trig();
                chk(chan_off == (f >= thr(s)), "R12 threshold", chan_off, (f >= thr(s)));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule